// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds return addresses for a small processor core. On a call or an accepted interrupt, the core asserts `push` with the program-counter value on `din`. On any kind of return, it asserts `pop` and collects the restored address from `dout` one cycle later. Sixteen 16-bit entries sit in private storage outside every memory map. The 4-bit pointer that indexes them has no read or write path.

The stack never reports an error. When pushes run past the last slot, the pointer wraps and the oldest entries are overwritten. When pops run below the first slot, the pointer wraps to the top. Software watches a single status pin, `avail`, instead. It is high after reset and low while the pointer sits on the last slot. Once a push has carried the pointer from the last slot back to slot 0, it is held low until the next reset. Push and pop are single-cycle strobes with no back-pressure: the stack accepts one operation in every cycle and never stalls the core. Any upper-address latch kept by the core is outside this block and is untouched by both operations.

Top module: `retaddr_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer goes to 0, every entry is cleared to 0, `dout` goes to 0 and `avail` goes high.
- R2: A push stores `din` at the pointer and then advances the pointer by one. A pop first steps the pointer back by one and then reads the entry there, so values return in last-in, first-out order.
- R3: `dout` changes only in the cycle after a pop and holds its value through idle cycles and pushes.
- R4: `avail` is low whenever the pointer equals 15. After 14 pushes from reset it is still high; after the 15th it is low; a pop that follows brings it high again.
- R5: A push made while the pointer is 15 wraps the pointer to 0 and locks `avail` low. No later pop or push releases it; only reset does.
- R6: Pushes beyond sixteen overwrite the oldest entries. After 18 pushes v1..v18, sixteen pops return v18, v17, ..., v3 (v17 replaced v1 and v18 replaced v2).
- R7: A pop issued straight after reset moves the pointer to 15, so `avail` goes low. A push that follows writes slot 15, wraps the pointer and locks `avail` low. A pop after that returns the pushed value.
- R8: When `push` and `pop` are both high in one cycle, the pop is performed and the push is ignored: nothing is written and the pointer only steps back.
- R9: Reset releases a locked `avail`, which reads high again after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Store `din` and advance the pointer (call or interrupt entry) |
| pop | input | 1 | Step the pointer back and read the entry (any return); wins over `push` |
| din | input | 16 | Address to save |
| dout | output | 16 | Most recently popped address, registered |
| avail | output | 1 | High while the stack can take another push without wrapping; locked low after a push wrap |

## Verification
A popped address appears on `dout` after the clock edge that samples `pop`. The monitor therefore waits for an edge where `pop` is high and compares `dout` with the next queued item at the following falling edge. `avail` follows the pointer and lock state through no further register, so it is correct right after the edge that performs the operation. The bench checks it at the falling edge that follows each operation. Pushes are checked only through what later pops return and through `dout` staying unchanged.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;

  // Pop takes priority over push when both strobes arrive together.
  function automatic stk_op_e resolve_op(input logic push, input logic pop);
    if (pop)       return OP_POP;
    else if (push) return OP_PUSH;
    else           return OP_IDLE;
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stk_pkg::stk_op_e     op,
  output logic [PTR_W-1:0]     sp_q,
  output logic [PTR_W-1:0]     sp_dec,
  output logic                 lock_q,
  output logic                 avail
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] sp_inc;
  logic             at_top;

  assign at_top = (sp_q == TOP);
  assign sp_inc = at_top ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? TOP : sp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      case (op)
        stk_pkg::OP_PUSH: begin
          sp_q <= sp_inc;
          if (at_top) lock_q <= 1'b1;
        end
        stk_pkg::OP_POP: sp_q <= sp_dec;
        default: ;
      endcase
    end
  end

  assign avail = !lock_q && !at_top;
endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[g] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(g)))
        slot[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= slot[rd_idx];
  end
endmodule

// File: rtl/retaddr_stack.sv
module retaddr_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             avail
);
  localparam int PTR_W = $clog2(DEPTH);

  stk_pkg::stk_op_e op;
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_dec;
  logic             lock_q;

  assign op = stk_pkg::resolve_op(push, pop);

  stk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .sp_q   (sp_q),
    .sp_dec (sp_dec),
    .lock_q (lock_q),
    .avail  (avail)
  );

  stk_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (op == stk_pkg::OP_PUSH),
    .wr_idx  (sp_q),
    .wr_data (din),
    .rd_en   (op == stk_pkg::OP_POP),
    .rd_idx  (sp_dec),
    .rd_data (dout)
  );
endmodule

// File: rtl/retaddr_stack_chk.sv
module retaddr_stack_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] dout,
  input logic             avail,
  input logic [PTR_W-1:0] sp_q,
  input logic             lock_q
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH - 1);

  assert_push_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> sp_q == (($past(sp_q) == TOP) ? '0 : PTR_W'($past(sp_q) + 1'b1)));

  assert_pop_retreat_R8: assert property (@(posedge clk) disable iff (rst)
    pop |=> sp_q == (($past(sp_q) == '0) ? TOP : PTR_W'($past(sp_q) - 1'b1)));

  assert_dout_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(dout));

  assert_top_unavail_R4: assert property (@(posedge clk) disable iff (rst)
    (sp_q == TOP) |-> !avail);

  assert_wrap_locks_R5: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && sp_q == TOP) |=> (lock_q && !avail));

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> (lock_q && !avail));
endmodule

bind retaddr_stack retaddr_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .push   (push),
  .pop    (pop),
  .dout   (dout),
  .avail  (avail),
  .sp_q   (sp_q),
  .lock_q (lock_q)
);

// File: tb/sim_retaddr_stack.sv
`timescale 1ns/1ps
module sim_retaddr_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        avail;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] m_mem [16];
  int          m_sp;

  always #2.5 clk = ~clk;

  retaddr_stack u0 (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .din(din), .dout(dout), .avail(avail)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation and queues the expected popped value.
  task automatic step(input logic ps, input logic pp, input logic [15:0] d, input string tag);
    @(negedge clk);
    push = ps; pop = pp; din = d;
    if (pp) begin
      m_sp = (m_sp + 15) % 16;
      exp_q.push_back(m_mem[m_sp]);
      tag_q.push_back(tag);
    end else if (ps) begin
      m_mem[m_sp] = d;
      m_sp = (m_sp + 1) % 16;
    end
    @(posedge clk);
    #1 push = 1'b0; pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    m_sp = 0;
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    @(negedge clk);
  endtask

  // Monitor: every sampled pop yields a result one edge later.
  initial begin
    forever begin
      @(posedge clk);
      if (pop === 1'b1 && rst === 1'b0) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected pop result actual %h expected none", dout);
        end else begin
          check(tag_q.pop_front(), dout, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    do_reset();
    check("R1 avail after reset", {15'd0, avail}, 16'd1);
    check("R1 dout after reset", dout, 16'h0000);

    // LIFO order
    step(1, 0, 16'h1111, "R2");
    step(1, 0, 16'h2222, "R2");
    step(1, 0, 16'h3333, "R2");
    step(0, 1, '0, "R2 lifo first");
    step(0, 1, '0, "R2 lifo second");
    held = 16'h2222;
    step(1, 0, 16'h4444, "R3");
    step(0, 0, '0, "R3");
    check("R3 dout held across push/idle", dout, held);
    step(0, 1, '0, "R2 after push");
    step(0, 1, '0, "R2 bottom");

    // Availability near the top
    do_reset();
    for (int i = 0; i < 14; i++) step(1, 0, 16'h0A00 + 16'(i), "R4");
    check("R4 avail after 14 pushes", {15'd0, avail}, 16'd1);
    step(1, 0, 16'h0A0E, "R4");
    check("R4 avail low at pointer 15", {15'd0, avail}, 16'd0);
    step(0, 1, '0, "R4 pop value");
    check("R4 avail back after pop", {15'd0, avail}, 16'd1);

    // Overwrite order and lock
    do_reset();
    for (int i = 1; i <= 18; i++) step(1, 0, 16'h1000 + 16'(i), "R6");
    check("R5 avail locked after wrap", {15'd0, avail}, 16'd0);
    for (int i = 0; i < 16; i++) step(0, 1, '0, "R6 overwrite order");
    check("R5 avail still locked after pops", {15'd0, avail}, 16'd0);
    do_reset();
    check("R9 reset releases lock", {15'd0, avail}, 16'd1);

    // Pop straight after reset
    step(0, 1, '0, "R7 reset-pop value");
    check("R7 avail low after pop at reset", {15'd0, avail}, 16'd0);
    step(1, 0, 16'hBEEF, "R7");
    check("R7 avail locked after push", {15'd0, avail}, 16'd0);
    step(0, 1, '0, "R7 pushed value");
    check("R7 avail stays locked", {15'd0, avail}, 16'd0);

    // Simultaneous push and pop
    do_reset();
    step(1, 0, 16'hAAAA, "R8");
    step(1, 0, 16'hBBBB, "R8");
    step(1, 1, 16'hCCCC, "R8 pop wins");
    step(0, 1, '0, "R8 push ignored");
    step(0, 1, '0, "R8 storage intact");
    check("R8 avail low after pointer reaches 15", {15'd0, avail}, 16'd0);

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule